// File: doc/BRIEF.md
# Processor Stop-Clock Power-State Controller

This block tracks the power state of one processor core sitting on a front-side bus, and it runs on the bus clock. It has five states: normal execution, halt, a snoop state entered from halt, stop-grant, and a snoop state entered from stop-grant. Halt is entered when a halt or monitor-wait event coincides with a completed halt bus cycle. Any wake event (init, bus-init, maskable or non-maskable interrupt, system-management interrupt, reset or a bus interrupt) returns the core from halt to normal execution. A snoop in either low-power state moves the core into the matching snoop state until the snoop is serviced.

A stop-clock request is active-low and is sampled as a level. When it is asserted in normal or halt, the block asks for the acknowledge bus cycle to be issued, waits for that cycle's response phase to complete, and then counts a fixed number of bus clocks (20 by default) before it reports stop-grant. Releasing stop-clock before stop-grant has been reached is a protocol violation: the block flags it and otherwise ignores it. While in stop-grant, a bus-init event is held in a sticky flag for software to clear later, and a reset event pulses a core-initialize output but does not leave stop-grant.

Top module: `stopclk_pwr_ctrl`

## Requirements
- R1: After synchronous reset, `state_oh` is 5'b00001 (normal), and `ack_req`, `binit_latched`, `core_init` and `proto_viol` are 0. The state encoding is: bit 0 normal, bit 1 halt, bit 2 halt-snoop, bit 3 stop-grant, bit 4 stop-grant-snoop. Exactly one bit is set at all times.
- R2: In normal, the controller moves to halt on the next edge only if `halt_evt` and `halt_cyc_done` are both high. Either one alone leaves it in normal.
- R3: In halt, any of the seven wake inputs moves the controller to normal on the next edge. This takes precedence over a snoop in the same cycle.
- R4: `snoop_det` moves halt to halt-snoop and stop-grant to stop-grant-snoop. `snoop_done` moves each snoop state back to the state it came from. Other inputs do not move the controller out of a snoop state.
- R5: If `stpclk_n` is low in normal or halt and no entry is pending, `ack_req` is high for exactly one cycle after that edge. The state then holds until stop-grant is entered.
- R6: After the acknowledge request, the first edge at which `ack_resp_done` is high starts the countdown. Stop-grant is entered exactly SG_DELAY (default 20) edges later, and not before.
- R7: In stop-grant, `stpclk_n` high moves the controller to normal on the next edge. This takes precedence over a snoop.
- R8: `stpclk_n` high while an entry is pending (acknowledge or countdown) makes `proto_viol` high in the following cycle. It does not change the state or the timing of stop-grant entry.
- R9: `wake_binit` in stop-grant or stop-grant-snoop sets `binit_latched`, which stays set until `binit_clr`, including after the return to normal. If set and clear arrive together, set wins.
- R10: `wake_reset` in stop-grant or stop-grant-snoop makes `core_init` high for the next cycle. The controller stays in stop-grant while `stpclk_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stpclk_n | input | 1 | Stop-clock request, active low |
| halt_evt | input | 1 | Halt or monitor-wait event |
| halt_cyc_done | input | 1 | Halt bus cycle has been issued |
| ack_resp_done | input | 1 | Response phase of the acknowledge cycle complete |
| snoop_det | input | 1 | Snoop detected on the bus |
| snoop_done | input | 1 | Snoop has been serviced |
| wake_init | input | 1 | Init wake event |
| wake_binit | input | 1 | Bus-init wake event |
| wake_intr | input | 1 | Maskable interrupt |
| wake_nmi | input | 1 | Non-maskable interrupt |
| wake_smi | input | 1 | System-management interrupt |
| wake_reset | input | 1 | Reset wake event |
| wake_busint | input | 1 | Interrupt delivered over the bus |
| binit_clr | input | 1 | Software clear of the latched bus-init flag |
| state_oh | output | 5 | One-hot power state |
| ack_req | output | 1 | One-cycle request to issue the acknowledge cycle |
| binit_latched | output | 1 | Sticky bus-init flag |
| core_init | output | 1 | One-cycle core-initialize pulse |
| proto_viol | output | 1 | Stop-clock released before stop-grant was reached |

## Verification
A wrong countdown value or a wrong pending phase shows at `state_oh`: the stop-grant bit rises too early or too late relative to the edge that sampled `ack_resp_done`. This is visible exactly SG_DELAY cycles after that edge. A wrong state register shows one cycle after the input that should have moved it, as a wrong bit in `state_oh`, a missing `ack_req`, or a `core_init` pulse in the wrong state. A lost sticky flag shows only when `binit_latched` is observed after the return to normal, so the bench reads it both before and after the exit.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [2:0] {
      PS_NORM = 3'd0,
      PS_HALT = 3'd1,
      PS_HSNP = 3'd2,
      PS_SGNT = 3'd3,
      PS_SSNP = 3'd4
   } pstate_e;

   localparam int unsigned NUM_PS = 5;

   typedef enum logic [1:0] {
      PD_IDLE = 2'd0,
      PD_WAIT = 2'd1,
      PD_CNT  = 2'd2
   } pend_e;
endpackage

// File: rtl/sgnt_timer.sv
module sgnt_timer
   import pwr_pkg::*;
#(
   parameter int unsigned DELAY = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic resp_done,
   input  logic stpclk_n,
   output logic ack_req,
   output logic pending,
   output logic grant_go,
   output logic proto_viol
);
   localparam int unsigned CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("sgnt_timer: DELAY must be at least 1");
      end
   endgenerate

   pend_e            pend_q;
   logic [CNT_W-1:0] cnt_q;

   assign pending  = (pend_q != PD_IDLE);
   assign grant_go = (pend_q == PD_CNT) && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q     <= PD_IDLE;
         cnt_q      <= '0;
         ack_req    <= 1'b0;
         proto_viol <= 1'b0;
      end else begin
         ack_req    <= 1'b0;
         proto_viol <= pending && stpclk_n;
         case (pend_q)
            PD_IDLE: begin
               if (start) begin
                  pend_q  <= PD_WAIT;
                  ack_req <= 1'b1;
               end
            end
            PD_WAIT: begin
               if (resp_done) begin
                  pend_q <= PD_CNT;
                  cnt_q  <= CNT_W'(DELAY - 1);
               end
            end
            PD_CNT: begin
               if (cnt_q == '0) pend_q <= PD_IDLE;
               else             cnt_q  <= cnt_q - CNT_W'(1);
            end
            default: pend_q <= PD_IDLE;
         endcase
      end
   end

   AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      ack_req |=> !ack_req); // R5
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
      ack_req |-> pending); // R5
endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
   import pwr_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    stpclk_n,
   input  logic    halt_evt,
   input  logic    halt_cyc_done,
   input  logic    snoop_det,
   input  logic    snoop_done,
   input  logic    wake_any,
   input  logic    pending,
   input  logic    grant_go,
   output pstate_e state,
   output logic    start
);
   assign start = !pending && !stpclk_n && ((state == PS_NORM) || (state == PS_HALT));

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= PS_NORM;
      end else if (grant_go) begin
         state <= PS_SGNT;
      end else if (!pending && !start) begin
         case (state)
            PS_NORM: if (halt_evt && halt_cyc_done) state <= PS_HALT;
            PS_HALT: begin
               if (wake_any)       state <= PS_NORM;
               else if (snoop_det) state <= PS_HSNP;
            end
            PS_HSNP: if (snoop_done) state <= PS_HALT;
            PS_SGNT: begin
               if (stpclk_n)       state <= PS_NORM;
               else if (snoop_det) state <= PS_SSNP;
            end
            PS_SSNP: if (snoop_done) state <= PS_SGNT;
            default: state <= PS_NORM;
         endcase
      end
   end

   AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
      (pending && !grant_go) |=> $stable(state)); // R5
   AST_SG_VIA_TIMER: assert property (@(posedge clk) disable iff (rst)
      ((state != PS_SGNT) && (state != PS_SSNP) && !grant_go) |=> (state != PS_SGNT)); // R6
   AST_HALT_WAKE: assert property (@(posedge clk) disable iff (rst)
      ((state == PS_HALT) && wake_any && !pending && stpclk_n) |=> (state == PS_NORM)); // R3
endmodule

// File: rtl/sg_event_latch.sv
module sg_event_latch (
   input  logic clk,
   input  logic rst,
   input  logic in_sg,
   input  logic wake_binit,
   input  logic wake_reset,
   input  logic binit_clr,
   output logic binit_latched,
   output logic core_init
);
   always_ff @(posedge clk) begin
      if (rst) begin
         binit_latched <= 1'b0;
         core_init     <= 1'b0;
      end else begin
         core_init <= in_sg && wake_reset;
         if (in_sg && wake_binit) binit_latched <= 1'b1;
         else if (binit_clr)      binit_latched <= 1'b0;
      end
   end

   AST_BINIT_STICKY: assert property (@(posedge clk) disable iff (rst)
      (binit_latched && !binit_clr) |=> binit_latched); // R9
   AST_INIT_PULSE: assert property (@(posedge clk) disable iff (rst)
      (core_init && !(in_sg && wake_reset)) |=> !core_init); // R10
endmodule

// File: rtl/stopclk_pwr_ctrl.sv
module stopclk_pwr_ctrl
   import pwr_pkg::*;
#(
   parameter int unsigned SG_DELAY = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stpclk_n,
   input  logic              halt_evt,
   input  logic              halt_cyc_done,
   input  logic              ack_resp_done,
   input  logic              snoop_det,
   input  logic              snoop_done,
   input  logic              wake_init,
   input  logic              wake_binit,
   input  logic              wake_intr,
   input  logic              wake_nmi,
   input  logic              wake_smi,
   input  logic              wake_reset,
   input  logic              wake_busint,
   input  logic              binit_clr,
   output logic [NUM_PS-1:0] state_oh,
   output logic              ack_req,
   output logic              binit_latched,
   output logic              core_init,
   output logic              proto_viol
);
   pstate_e state;
   logic    start, pending, grant_go, wake_any, in_sg;

   assign wake_any = wake_init | wake_binit | wake_intr | wake_nmi |
                     wake_smi | wake_reset | wake_busint;
   assign in_sg    = (state == PS_SGNT) || (state == PS_SSNP);

   pstate_fsm u_fsm (
      .clk           (clk),
      .rst           (rst),
      .stpclk_n      (stpclk_n),
      .halt_evt      (halt_evt),
      .halt_cyc_done (halt_cyc_done),
      .snoop_det     (snoop_det),
      .snoop_done    (snoop_done),
      .wake_any      (wake_any),
      .pending       (pending),
      .grant_go      (grant_go),
      .state         (state),
      .start         (start)
   );

   sgnt_timer #(.DELAY(SG_DELAY)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .resp_done  (ack_resp_done),
      .stpclk_n   (stpclk_n),
      .ack_req    (ack_req),
      .pending    (pending),
      .grant_go   (grant_go),
      .proto_viol (proto_viol)
   );

   sg_event_latch u_latch (
      .clk           (clk),
      .rst           (rst),
      .in_sg         (in_sg),
      .wake_binit    (wake_binit),
      .wake_reset    (wake_reset),
      .binit_clr     (binit_clr),
      .binit_latched (binit_latched),
      .core_init     (core_init)
   );

   generate
      for (genvar i = 0; i < NUM_PS; i++) begin : g_oh
         assign state_oh[i] = (state == pstate_e'(i));
      end
   endgenerate

   AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
      $countones(state_oh) == 1); // R1
   AST_EXIT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (state_oh[PS_SGNT] && stpclk_n) |=> state_oh[PS_NORM]); // R7
   AST_RESET_STAYS_SG: assert property (@(posedge clk) disable iff (rst)
      ((state_oh[PS_SGNT] || state_oh[PS_SSNP]) && wake_reset && !stpclk_n)
      |=> (core_init && (state_oh[PS_SGNT] || state_oh[PS_SSNP]))); // R10
   AST_VIOL_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (rst)
      (grant_go && stpclk_n) |=> state_oh[PS_SGNT]); // R8
endmodule

// File: tb/tb_stopclk_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_stopclk_pwr_ctrl;
   localparam int DLY = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic stpclk_n = 1'b1, halt_evt = 0, halt_cyc_done = 0, ack_resp_done = 0;
   logic snoop_det = 0, snoop_done = 0;
   logic wake_init = 0, wake_binit = 0, wake_intr = 0, wake_nmi = 0;
   logic wake_smi = 0, wake_reset = 0, wake_busint = 0, binit_clr = 0;
   logic [4:0] state_oh;
   logic ack_req, binit_latched, core_init, proto_viol;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   stopclk_pwr_ctrl #(.SG_DELAY(DLY)) dut (.*);

   // reference model: state index 0..4 per bit of state_oh
   int m_st = 0, m_ph = 0, m_rem = 0;
   bit m_ack = 0, m_binit = 0, m_init = 0, m_viol = 0;

   function automatic bit any_wake();
      return wake_init | wake_binit | wake_intr | wake_nmi | wake_smi | wake_reset | wake_busint;
   endfunction

   task automatic model_step();
      int nst;
      if (rst) begin
         m_st = 0; m_ph = 0; m_rem = 0;
         m_ack = 0; m_binit = 0; m_init = 0; m_viol = 0;
         return;
      end
      nst = m_st;
      m_viol = (m_ph != 0) && stpclk_n;
      m_init = (m_st >= 3) && wake_reset;
      if ((m_st >= 3) && wake_binit) m_binit = 1;
      else if (binit_clr)            m_binit = 0;
      m_ack = 0;
      if (m_ph == 2) begin
         m_rem--;
         if (m_rem == 0) begin nst = 3; m_ph = 0; end
      end else if (m_ph == 1) begin
         if (ack_resp_done) begin m_ph = 2; m_rem = DLY; end
      end else if (!stpclk_n && (m_st <= 1)) begin
         m_ph = 1; m_ack = 1;
      end else begin
         case (m_st)
            0: if (halt_evt && halt_cyc_done) nst = 1;
            1: if (any_wake()) nst = 0; else if (snoop_det) nst = 2;
            2: if (snoop_done) nst = 1;
            3: if (stpclk_n) nst = 0; else if (snoop_det) nst = 4;
            4: if (snoop_done) nst = 3;
            default: nst = 0;
         endcase
      end
      m_st = nst;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("R1 state", {27'd0, state_oh}, 32'd1 << m_st);
      chk("R5 ack_req", {31'd0, ack_req}, {31'd0, m_ack});
      chk("R9 binit_latched", {31'd0, binit_latched}, {31'd0, m_binit});
      chk("R10 core_init", {31'd0, core_init}, {31'd0, m_init});
      chk("R8 proto_viol", {31'd0, proto_viol}, {31'd0, m_viol});
   endtask

   task automatic quiet();
      halt_evt = 0; halt_cyc_done = 0; ack_resp_done = 0; snoop_det = 0; snoop_done = 0;
      wake_init = 0; wake_binit = 0; wake_intr = 0; wake_nmi = 0;
      wake_smi = 0; wake_reset = 0; wake_busint = 0; binit_clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst = 1; quiet(); stpclk_n = 1;
      cyc(); cyc();
      rst = 0;
      cyc();
      chk("R1 reset state", {27'd0, state_oh}, 32'd1);
      chk("R1 reset flags", {28'd0, ack_req, binit_latched, core_init, proto_viol}, 32'd0);

      // R2: halt needs both conditions
      halt_evt = 1; cyc();
      chk("R2 halt_evt alone", {27'd0, state_oh}, 32'd1);
      halt_evt = 0; halt_cyc_done = 1; cyc();
      chk("R2 cycle alone", {27'd0, state_oh}, 32'd1);
      halt_evt = 1; cyc(); quiet();
      chk("R2 enter halt", {27'd0, state_oh}, 32'd2);
      // R4 halt snoop pair
      snoop_det = 1; cyc(); quiet();
      chk("R4 halt snoop", {27'd0, state_oh}, 32'd4);
      wake_intr = 1; cyc(); quiet();
      chk("R4 wake ignored in snoop", {27'd0, state_oh}, 32'd4);
      snoop_done = 1; cyc(); quiet();
      chk("R4 snoop serviced", {27'd0, state_oh}, 32'd2);
      // R3 wake beats snoop
      wake_nmi = 1; snoop_det = 1; cyc(); quiet();
      chk("R3 wake to normal", {27'd0, state_oh}, 32'd1);

      // R5 / R6 exact delay
      stpclk_n = 0; cyc();
      chk("R5 ack pulse", {31'd0, ack_req}, 32'd1);
      cyc();
      chk("R5 ack one cycle", {31'd0, ack_req}, 32'd0);
      ack_resp_done = 1; cyc(); ack_resp_done = 0;
      for (int k = 1; k < DLY; k++) begin
         cyc();
         chk("R6 not yet in stop-grant", {27'd0, state_oh}, 32'd1);
      end
      cyc();
      chk("R6 stop-grant after delay", {27'd0, state_oh}, 32'd8);

      // R9 / R10 in stop-grant
      wake_binit = 1; cyc(); quiet();
      chk("R9 binit latched", {31'd0, binit_latched}, 32'd1);
      chk("R9 binit not serviced", {27'd0, state_oh}, 32'd8);
      wake_reset = 1; cyc(); quiet();
      chk("R10 core_init pulse", {31'd0, core_init}, 32'd1);
      chk("R10 stays stop-grant", {27'd0, state_oh}, 32'd8);
      cyc();
      chk("R10 pulse ends", {31'd0, core_init}, 32'd0);
      // R4 stop-grant snoop pair
      snoop_det = 1; cyc(); quiet();
      chk("R4 sg snoop", {27'd0, state_oh}, 32'd16);
      snoop_done = 1; cyc(); quiet();
      chk("R4 sg snoop serviced", {27'd0, state_oh}, 32'd8);
      // R7 release beats snoop
      stpclk_n = 1; snoop_det = 1; cyc(); quiet();
      chk("R7 exit to normal", {27'd0, state_oh}, 32'd1);
      chk("R9 flag survives exit", {31'd0, binit_latched}, 32'd1);
      wake_binit = 0; binit_clr = 1; cyc(); quiet();
      chk("R9 flag cleared", {31'd0, binit_latched}, 32'd0);

      // R8 early release
      stpclk_n = 0; cyc();
      stpclk_n = 1; cyc();
      chk("R8 violation flagged", {31'd0, proto_viol}, 32'd1);
      chk("R8 state held", {27'd0, state_oh}, 32'd1);
      ack_resp_done = 1; cyc(); ack_resp_done = 0;
      for (int k = 1; k < DLY; k++) cyc();
      cyc();
      chk("R8 entry unaffected", {27'd0, state_oh}, 32'd8);
      cyc();
      chk("R7 release after entry", {27'd0, state_oh}, 32'd1);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         quiet();
         if ($urandom_range(39) == 0) stpclk_n = ~stpclk_n;
         halt_evt      = ($urandom_range(5) == 0);
         halt_cyc_done = ($urandom_range(1) == 0);
         ack_resp_done = ($urandom_range(3) == 0);
         snoop_det     = ($urandom_range(5) == 0);
         snoop_done    = ($urandom_range(2) == 0);
         wake_init     = ($urandom_range(39) == 0);
         wake_binit    = ($urandom_range(29) == 0);
         wake_intr     = ($urandom_range(39) == 0);
         wake_nmi      = ($urandom_range(59) == 0);
         wake_smi      = ($urandom_range(59) == 0);
         wake_reset    = ($urandom_range(29) == 0);
         wake_busint   = ($urandom_range(39) == 0);
         binit_clr     = ($urandom_range(19) == 0);
         cyc();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule